// File: doc/BRIEF.md
# Grouped priority interrupt resolver

This block picks one interrupt source to service from a set of pending requests. Each of the 16 sources has its own 8-bit priority register. A smaller value is more urgent, and 0 is the most urgent value. Only the three most significant bits of each priority are stored. A 3-bit group code, set at run time, splits every priority into a pre-emption part and a sub-priority part. The block reports the winning source, the two parts of its priority, and a registered request that says whether the winner should interrupt the handler that is running now.

Software loads the priorities and the group code through a write port with an enable, an address and data. The same address selects what appears on a registered read-back bus one clock later. The interrupt controller drives the pending vector, plus the priority of the running handler when one is active. It then reads the winner and the pre-empt request from registered outputs.

Top module: `prio_resolver`

## Requirements
- R1: After synchronous reset, all outputs are zero, every priority register reads 0 and the group code reads 0.
- R2: Address values with bit 4 clear select the priority register of source `cfg_addr[3:0]`. Only bits [7:5] are stored. Bits [4:0] always read back as zero, whatever was written.
- R3: Address value 16 (bit 4 set) selects the group code. It stores `cfg_wdata[2:0]` and reads back zero-extended. Read data appears on `cfg_rdata` one clock after the address is presented.
- R4: Among the pending sources, the winner is the one with the numerically smallest priority value. Comparing the pre-emption parts first and the sub-priority parts second gives the same order.
- R5: When the pending sources with the lowest priority value are tied, the lowest source number wins.
- R6: For group code g below 7, `win_pre` is `priority >> (g+1)` and `win_sub` is the low g+1 bits of the priority. For g = 7, `win_pre` is 0 and `win_sub` is the whole priority.
- R7: When a handler is running, `preempt_req` is high only if the winner's pre-emption part is strictly smaller than the pre-emption part of `act_prio`, split with the same group code. A winner that is more urgent only in its sub-priority never pre-empts.
- R8: When no handler is running, `preempt_req` is high whenever some source is pending.
- R9: With nothing pending, `win_valid` and `preempt_req` are low, and `win_idx`, `win_pre` and `win_sub` are zero.
- R10: The outputs show the result for the pending inputs and register contents of the previous clock. A change in pending inputs, or a register write, appears at the outputs exactly one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 5 | Register address: bit 4 clear selects a source priority register, value 16 selects the group code |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read-back of the addressed register |
| pend | input | 16 | Pending request per source |
| act_valid | input | 1 | A handler is running |
| act_prio | input | 8 | Priority of the running handler |
| win_valid | output | 1 | At least one source was pending |
| win_idx | output | 4 | Winning source number |
| win_pre | output | 8 | Pre-emption part of the winner's priority |
| win_sub | output | 8 | Sub-priority part of the winner's priority |
| preempt_req | output | 1 | The winner should pre-empt the running handler |

## Verification
The hardest case to reach is a winner that is more urgent than the running handler only in its sub-priority. It needs a group code that puts some stored bits into the sub-priority part, and a handler priority with the same pre-emption part. The bench reaches it by switching the group code to 5, where priority bit 5 falls into the sub-priority part. It then pairs a pending source of priority 0x00 with a running handler of priority 0x20. The bench also times pending and register changes between clock edges. This confirms the outputs lag by exactly one clock.

// File: rtl/prio_pkg.sv
package prio_pkg;
  localparam int PRIO_W = 8;
  localparam int GRP_W  = $clog2(PRIO_W);
  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [GRP_W-1:0]  grp_t;
endpackage

// File: rtl/prio_regfile.sv
module prio_regfile
  import prio_pkg::*;
#(
  parameter int NUM_SRC   = 16,
  parameter int IMPL_BITS = 3,
  parameter int IDX_W     = $clog2(NUM_SRC)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [IDX_W:0] addr,
  input  prio_t          wdata,
  output prio_t          rdata,
  output prio_t          prio_arr [NUM_SRC],
  output grp_t           grp
);
  localparam int LOW_BITS = PRIO_W - IMPL_BITS;

  logic [IMPL_BITS-1:0] hi_q [NUM_SRC];
  grp_t                 grp_q;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst)
        hi_q[s] <= '0;
      else if (we && !addr[IDX_W] && addr[IDX_W-1:0] == IDX_W'(s))
        hi_q[s] <= wdata[PRIO_W-1 -: IMPL_BITS];
    end
    assign prio_arr[s] = {hi_q[s], {LOW_BITS{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst)
      grp_q <= '0;
    else if (we && addr[IDX_W])
      grp_q <= wdata[GRP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (addr[IDX_W])
      rdata <= prio_t'(grp_q);
    else
      rdata <= prio_arr[addr[IDX_W-1:0]];
  end

  assign grp = grp_q;
endmodule

// File: rtl/prio_split.sv
module prio_split
  import prio_pkg::*;
(
  input  prio_t prio,
  input  grp_t  grp,
  output prio_t pre,
  output prio_t sub
);
  logic [PRIO_W:0] span;
  logic [GRP_W:0]  shamt;

  always_comb begin
    span  = (PRIO_W+1)'(2) << grp;
    span  = span - (PRIO_W+1)'(1);
    shamt = {1'b0, grp} + (GRP_W+1)'(1);
    sub   = prio & span[PRIO_W-1:0];
    pre   = (grp == '1) ? '0 : (prio >> shamt);
  end
endmodule

// File: rtl/prio_arb_tree.sv
module prio_arb_tree
  import prio_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] pend,
  input  prio_t              prio_arr [NUM_SRC],
  output logic               any,
  output logic [IDX_W-1:0]   idx,
  output prio_t              prio
);
  localparam int NODES = 2 * NUM_SRC - 1;

  logic             nv [NODES];
  prio_t            np [NODES];
  logic [IDX_W-1:0] ni [NODES];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_leaf
    assign nv[NUM_SRC-1+s] = pend[s];
    assign np[NUM_SRC-1+s] = prio_arr[s];
    assign ni[NUM_SRC-1+s] = IDX_W'(s);
  end

  for (genvar n = 0; n < NUM_SRC - 1; n++) begin : g_node
    localparam int L = 2 * n + 1;
    localparam int R = 2 * n + 2;
    logic take_r;
    assign take_r = nv[R] && (!nv[L] || (np[R] < np[L]));
    assign nv[n]  = nv[L] | nv[R];
    assign np[n]  = take_r ? np[R] : np[L];
    assign ni[n]  = take_r ? ni[R] : ni[L];
  end

  assign any  = nv[0];
  assign idx  = ni[0];
  assign prio = np[0];
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
  import prio_pkg::*;
#(
  parameter int NUM_SRC   = 16,
  parameter int IMPL_BITS = 3,
  parameter int IDX_W     = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [IDX_W:0]     cfg_addr,
  input  logic [PRIO_W-1:0]  cfg_wdata,
  output logic [PRIO_W-1:0]  cfg_rdata,
  input  logic [NUM_SRC-1:0] pend,
  input  logic               act_valid,
  input  logic [PRIO_W-1:0]  act_prio,
  output logic               win_valid,
  output logic [IDX_W-1:0]   win_idx,
  output logic [PRIO_W-1:0]  win_pre,
  output logic [PRIO_W-1:0]  win_sub,
  output logic               preempt_req
);
  prio_t            prio_arr [NUM_SRC];
  grp_t             grp;
  logic             t_any;
  logic [IDX_W-1:0] t_idx;
  prio_t            t_prio;
  prio_t            w_pre, w_sub, a_pre, a_sub;

  prio_regfile #(.NUM_SRC(NUM_SRC), .IMPL_BITS(IMPL_BITS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .prio_arr(prio_arr), .grp(grp)
  );

  prio_arb_tree #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_tree (
    .pend(pend), .prio_arr(prio_arr), .any(t_any), .idx(t_idx), .prio(t_prio)
  );

  prio_split u_split_win (.prio(t_prio),   .grp(grp), .pre(w_pre), .sub(w_sub));
  prio_split u_split_act (.prio(act_prio), .grp(grp), .pre(a_pre), .sub(a_sub));

  always_ff @(posedge clk) begin
    if (rst) begin
      win_valid   <= 1'b0;
      win_idx     <= '0;
      win_pre     <= '0;
      win_sub     <= '0;
      preempt_req <= 1'b0;
    end else begin
      win_valid   <= t_any;
      win_idx     <= t_any ? t_idx : '0;
      win_pre     <= t_any ? w_pre : '0;
      win_sub     <= t_any ? w_sub : '0;
      preempt_req <= t_any && (!act_valid || (w_pre < a_pre));
    end
  end
endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
  parameter int NUM_SRC   = 16,
  parameter int IMPL_BITS = 3,
  parameter int IDX_W     = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst,
  input logic [IDX_W:0]     cfg_addr,
  input logic [7:0]         cfg_rdata,
  input logic [NUM_SRC-1:0] pend,
  input logic               act_valid,
  input logic               win_valid,
  input logic [IDX_W-1:0]   win_idx,
  input logic               preempt_req
);
  localparam int LOW_BITS = 8 - IMPL_BITS;

  logic [NUM_SRC-1:0] pend_q;
  logic               act_q;
  logic               sel_grp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= '0;
      act_q     <= 1'b0;
      sel_grp_q <= 1'b0;
    end else begin
      pend_q    <= pend;
      act_q     <= act_valid;
      sel_grp_q <= cfg_addr[IDX_W];
    end
  end

  a_r9_idle_outputs: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |=> (!win_valid && win_idx == '0 && !preempt_req));

  a_r10_valid_tracks: assert property (@(posedge clk) disable iff (rst)
    (pend != '0) |=> win_valid);

  a_r4_winner_pending: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> pend_q[win_idx]);

  a_r7_preempt_needs_winner: assert property (@(posedge clk) disable iff (rst)
    preempt_req |-> win_valid);

  a_r8_idle_core_takes: assert property (@(posedge clk) disable iff (rst)
    (win_valid && !act_q) |-> preempt_req);

  a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    !sel_grp_q |-> (cfg_rdata[LOW_BITS-1:0] == '0));
endmodule

bind prio_resolver prio_resolver_chk #(
  .NUM_SRC(NUM_SRC), .IMPL_BITS(IMPL_BITS), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .pend(pend), .act_valid(act_valid), .win_valid(win_valid),
  .win_idx(win_idx), .preempt_req(preempt_req)
);

// File: tb/prio_resolver_test.sv
module prio_resolver_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [15:0] pend = '0;
  logic        act_valid = 1'b0;
  logic [7:0]  act_prio = '0;
  logic        win_valid;
  logic [3:0]  win_idx;
  logic [7:0]  win_pre, win_sub;
  logic        preempt_req;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  prio_resolver uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pend(pend),
    .act_valid(act_valid), .act_prio(act_prio), .win_valid(win_valid),
    .win_idx(win_idx), .win_pre(win_pre), .win_sub(win_sub),
    .preempt_req(preempt_req)
  );

  // {pend, act_valid, act_prio, exp_valid, exp_idx, exp_pre, exp_sub, exp_preempt}, group code 3
  localparam logic [46:0] VEC [8] = '{
    {16'h0000, 1'b0, 8'h00, 1'b0, 4'd0,  8'd0,  8'd0, 1'b0},
    {16'h0020, 1'b0, 8'h00, 1'b1, 4'd5,  8'd6,  8'd0, 1'b1},
    {16'h0060, 1'b1, 8'h60, 1'b1, 4'd6,  8'd4,  8'd0, 1'b1},
    {16'h0208, 1'b1, 8'h20, 1'b1, 4'd3,  8'd2,  8'd0, 1'b0},
    {16'h0200, 1'b1, 8'h40, 1'b1, 4'd9,  8'd2,  8'd0, 1'b1},
    {16'hFFFF, 1'b1, 8'h00, 1'b1, 4'd12, 8'd0,  8'd0, 1'b0},
    {16'h8001, 1'b0, 8'h00, 1'b1, 4'd0,  8'd14, 8'd0, 1'b1},
    {16'h8000, 1'b1, 8'hE0, 1'b1, 4'd15, 8'd14, 8'd0, 1'b0}
  };

  task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic apply(input logic [15:0] p, input logic av, input logic [7:0] ap);
    @(negedge clk);
    pend = p; act_valid = av; act_prio = ap;
    @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic v, input logic [3:0] i,
                            input logic [7:0] pr, input logic [7:0] sb, input logic pe);
    expect_eq({tag, " R9 valid"}, 32'(win_valid), 32'(v));
    expect_eq({tag, " R4 idx"}, 32'(win_idx), 32'(i));
    expect_eq({tag, " R6 pre"}, 32'(win_pre), 32'(pr));
    expect_eq({tag, " R6 sub"}, 32'(win_sub), 32'(sb));
    expect_eq({tag, " R7 preempt"}, 32'(preempt_req), 32'(pe));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    expect_out("R1 reset", 1'b0, 4'd0, 8'd0, 8'd0, 1'b0);
    rd(5'd4, rv);  expect_eq("R1 prio reg after reset", 32'(rv), 32'h0);
    rd(5'h10, rv); expect_eq("R1 group after reset", 32'(rv), 32'h0);

    // R2 only upper three bits stored
    wr(5'd7, 8'hFF);
    rd(5'd7, rv); expect_eq("R2 readback of 0xFF", 32'(rv), 32'hE0);
    wr(5'd8, 8'h5F);
    rd(5'd8, rv); expect_eq("R2 readback of 0x5F", 32'(rv), 32'h40);

    // R3 group code
    wr(5'h10, 8'hFB);
    rd(5'h10, rv); expect_eq("R3 group readback", 32'(rv), 32'h3);

    for (int s = 0; s < 16; s++) wr(5'(s), 8'hE0);
    wr(5'd3, 8'h20); wr(5'd9, 8'h20); wr(5'd5, 8'h60);
    wr(5'd6, 8'h40); wr(5'd12, 8'h00);

    // table walk: R4, R5 (vec 3, 6), R7, R8, R9
    for (int k = 0; k < 8; k++) begin
      apply(VEC[k][46:31], VEC[k][30], VEC[k][29:22]);
      expect_out($sformatf("vec%0d", k), VEC[k][21], VEC[k][20:17],
                 VEC[k][16:9], VEC[k][8:1], VEC[k][0]);
    end

    // R5 tie between equal priorities, lowest number wins
    apply(16'h0208, 1'b0, 8'h00);
    expect_eq("R5 tie src3 vs src9", 32'(win_idx), 32'd3);

    // group 5: pre = [7:6], sub = [5:0]
    wr(5'h10, 8'h05);
    apply(16'h0048, 1'b1, 8'h40);
    expect_out("R6 grp5", 1'b1, 4'd3, 8'd0, 8'h20, 1'b1);
    apply(16'h1000, 1'b1, 8'h20);
    expect_out("R7 sub-only no preempt", 1'b1, 4'd12, 8'd0, 8'd0, 1'b0);

    // group 7: no pre-emption part
    wr(5'h10, 8'h07);
    apply(16'h0008, 1'b1, 8'hE0);
    expect_out("R6 grp7", 1'b1, 4'd3, 8'd0, 8'h20, 1'b0);
    apply(16'h0008, 1'b0, 8'hE0);
    expect_eq("R8 no handler preempt", 32'(preempt_req), 32'd1);

    // group 0: pre = [7:1], sub = [0]
    wr(5'h10, 8'h00);
    apply(16'h0020, 1'b1, 8'h62);
    expect_out("R6 grp0", 1'b1, 4'd5, 8'h30, 8'd0, 1'b1);

    // R10 pending change appears one clock later
    @(negedge clk);
    pend = 16'h0040;
    #3;
    expect_eq("R10 before edge", 32'(win_idx), 32'd5);
    @(negedge clk);
    expect_eq("R10 after edge", 32'(win_idx), 32'd6);

    // R10 register write appears one clock after the write edge
    pend = 16'h0060;
    @(negedge clk);
    expect_eq("R10 pre-write winner", 32'(win_idx), 32'd6);
    wr(5'd6, 8'hE0);
    expect_eq("R10 write edge lag", 32'(win_idx), 32'd6);
    @(negedge clk);
    expect_eq("R10 write visible", 32'(win_idx), 32'd5);

    // R9 nothing pending
    apply(16'h0000, 1'b0, 8'h00);
    expect_out("R9 idle", 1'b0, 4'd0, 8'd0, 8'd0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule